// File: doc/BRIEF.md
# Per-Thread Store Queue with Same-Thread Load Forwarding

This unit sits in the load-store stage of a pipeline that four hardware threads share. Each thread owns a private queue of pending stores. Each queue entry holds a physical word address, a data word and a byte-enable mask. A store is written into its own thread's queue. Stores leave the queue oldest-first through a single shared drain port toward a write-through next-level cache. An entry is released only when the cache acknowledges it. The first-level cache does not allocate on stores and sees no store until this acknowledgment, so a store becomes visible to other threads only after the next-level cache has taken it.

A load that has finished translation presents its thread, address and byte mask. The unit searches only that thread's queue, in the same cycle. The youngest entry with the same address and at least one shared byte decides the result. If that entry covers every requested byte, its data is forwarded. If it covers only some of them, the load is told to replay. Stores from other threads never affect a load.

The drain side is a two-state machine. In **IDLE** no request is out. The **IDLE→WAIT** transition fires when any queue is non-empty, and it picks a thread in round-robin order. In **WAIT** the head entry of the chosen thread is offered. The **WAIT→IDLE** transition fires on acknowledgment and frees that entry. While no acknowledgment arrives, the machine stays in WAIT. While every queue is empty, it stays in IDLE.

Top module: `thread_store_queue`

## Requirements
- R1: After reset all queues are empty, `st_stall` is all zero, `drain_valid` is 0, and a load sees neither `ld_hit` nor `ld_replay`.
- R2: A store with `st_valid` high is appended to queue `st_tid` when that queue is not full. `st_stall[t]` is 1 exactly while queue t holds DEPTH entries. A store offered to a full queue is dropped, and the other queues are unaffected.
- R3: In the same cycle as `ld_valid`, the youngest entry of queue `ld_tid` whose address equals `ld_addr` and whose mask shares a bit with `ld_mask` is selected. If the entry's mask covers all set bits of `ld_mask`, `ld_hit`=1 and `ld_data` equals that entry's data.
- R4: If the selected youngest entry covers only part of `ld_mask`, `ld_replay`=1 and `ld_hit`=0, even when an older entry would cover the load fully.
- R5: Entries in queues other than `ld_tid` never cause `ld_hit` or `ld_replay`, even at the same address.
- R6: With no selectable entry, or with `ld_valid` low, both `ld_hit` and `ld_replay` are 0. An entry at the same address whose mask has no common bit with `ld_mask` is not selectable.
- R7: Each queue drains oldest-first. While `drain_valid` is 1 and `drain_ack` is 0, the payload `drain_tid`, `drain_addr`, `drain_data` and `drain_mask` is held. The head entry is freed at the clock edge where `drain_valid` and `drain_ack` are both 1. Until then, the entry still forwards to loads.
- R8: After an acknowledgment for thread g, the next request goes to the first non-empty thread in the order g+1, g+2, … (modulo NUM_THR). After reset, thread 0 is first in this order.
- R9: `drain_ack` while `drain_valid` is 0 frees no entry. After an acknowledgment, `drain_valid` is 0 for one cycle before the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store presented this cycle |
| st_tid | input | TID_W | Thread of the store |
| st_addr | input | ADDR_W | Physical word address of the store |
| st_data | input | DATA_W | Store data |
| st_mask | input | DATA_W/8 | Byte enables of the store |
| st_stall | output | NUM_THR | Per-thread full indication |
| ld_valid | input | 1 | Translated load presented this cycle |
| ld_tid | input | TID_W | Thread of the load |
| ld_addr | input | ADDR_W | Physical word address of the load |
| ld_mask | input | DATA_W/8 | Bytes the load reads |
| ld_hit | output | 1 | Forwarding available |
| ld_replay | output | 1 | Partial overlap, load must replay |
| ld_data | output | DATA_W | Forwarded data word |
| drain_valid | output | 1 | Drain request to next-level cache |
| drain_tid | output | TID_W | Thread of the drained store |
| drain_addr | output | ADDR_W | Address of the drained store |
| drain_data | output | DATA_W | Data of the drained store |
| drain_mask | output | DATA_W/8 | Byte enables of the drained store |
| drain_ack | input | 1 | Next-level cache accepted the request |

## Verification
The hardest case to reach is a partial overlap. In that case the youngest matching store covers only some of the load's bytes, while an older store at the same address covers them all, so the age order matters and not just the presence of a match. The stimulus creates this by leaving `drain_ack` low. It pushes a full-word store and then a half-word store to one address, and it probes with loads of the lower half, the whole word and the upper half. It then acknowledges the older store and probes again. A second hard case is the rotation of the drain port across four full queues. The bench reaches it by filling every queue while holding back acknowledgments, and then checking all 32 drained entries in the order it predicts.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef enum logic {
        DR_IDLE = 1'b0,
        DR_WAIT = 1'b1
    } drain_state_e;
endpackage

// File: rtl/sq_thread_fifo.sv
module sq_thread_fifo #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  logic [ADDR_W-1:0]     push_addr,
    input  logic [DATA_W-1:0]     push_data,
    input  logic [DATA_W/8-1:0]   push_mask,
    input  logic                  pop,
    output logic                  full,
    output logic                  empty,
    output logic [ADDR_W-1:0]     head_addr,
    output logic [DATA_W-1:0]     head_data,
    output logic [DATA_W/8-1:0]   head_mask,
    input  logic [ADDR_W-1:0]     lk_addr,
    input  logic [DATA_W/8-1:0]   lk_mask,
    output logic                  lk_hit,
    output logic                  lk_partial,
    output logic [DATA_W-1:0]     lk_data
);
    localparam int MASK_W = DATA_W / 8;
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [MASK_W-1:0] mask_q [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  count;

    function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] base, input int off);
        logic [PTR_W:0] s;
        s = {1'b0, base} + (PTR_W+1)'(off);
        if (s >= (PTR_W+1)'(DEPTH)) s = s - (PTR_W+1)'(DEPTH);
        return s[PTR_W-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                addr_q[wr_ptr] <= push_addr;
                data_q[wr_ptr] <= push_data;
                mask_q[wr_ptr] <= push_mask;
                wr_ptr         <= wrap_add(wr_ptr, 1);
            end
            if (pop) rd_ptr <= wrap_add(rd_ptr, 1);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign full      = (count == CNT_W'(DEPTH));
    assign empty     = (count == '0);
    assign head_addr = addr_q[rd_ptr];
    assign head_data = data_q[rd_ptr];
    assign head_mask = mask_q[rd_ptr];

    // Walk from oldest to youngest; a later match overrides, so the youngest wins.
    always_comb begin
        logic              found;
        logic [MASK_W-1:0] f_mask;
        logic [DATA_W-1:0] f_data;
        logic [PTR_W-1:0]  idx;
        found  = 1'b0;
        f_mask = '0;
        f_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            idx = wrap_add(rd_ptr, i);
            if ((CNT_W'(i) < count) && (addr_q[idx] == lk_addr) &&
                ((mask_q[idx] & lk_mask) != '0)) begin
                found  = 1'b1;
                f_mask = mask_q[idx];
                f_data = data_q[idx];
            end
        end
        lk_hit     = found && ((lk_mask & ~f_mask) == '0);
        lk_partial = found && ((lk_mask & ~f_mask) != '0);
        lk_data    = f_data;
    end

    a_r2_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    a_r7_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/sq_drain_arb.sv
module sq_drain_arb
    import sq_pkg::*;
#(
    parameter int NUM_THR = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_THR-1:0]          nonempty,
    input  logic                        ack,
    output logic                        req,
    output logic [$clog2(NUM_THR)-1:0]  grant_tid,
    output logic [NUM_THR-1:0]          pop_vec
);
    localparam int TID_W = $clog2(NUM_THR);

    drain_state_e      state_q, state_d;
    logic [TID_W-1:0]  gnt_q, gnt_d, last_q, last_d, pick;
    logic              any_ready;

    // Round-robin: first non-empty thread after the last one served.
    always_comb begin
        logic [TID_W:0] s;
        any_ready = 1'b0;
        pick      = '0;
        for (int k = 1; k <= NUM_THR; k++) begin
            s = {1'b0, last_q} + (TID_W+1)'(k);
            if (s >= (TID_W+1)'(NUM_THR)) s = s - (TID_W+1)'(NUM_THR);
            if (!any_ready && nonempty[s[TID_W-1:0]]) begin
                any_ready = 1'b1;
                pick      = s[TID_W-1:0];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        gnt_d   = gnt_q;
        last_d  = last_q;
        unique case (state_q)
            DR_IDLE: if (any_ready) begin
                state_d = DR_WAIT;
                gnt_d   = pick;
            end
            DR_WAIT: if (ack) begin
                state_d = DR_IDLE;
                last_d  = gnt_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DR_IDLE;
            gnt_q   <= '0;
            last_q  <= TID_W'(NUM_THR - 1);
        end else begin
            state_q <= state_d;
            gnt_q   <= gnt_d;
            last_q  <= last_d;
        end
    end

    always_comb begin
        req       = 1'b0;
        pop_vec   = '0;
        grant_tid = gnt_q;
        unique case (state_q)
            DR_IDLE: ;
            DR_WAIT: begin
                req = 1'b1;
                if (ack) pop_vec[gnt_q] = 1'b1;
            end
        endcase
    end

    a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (req && $stable(grant_tid)));
    a_r7_grant_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> nonempty[grant_tid]);
    a_r9_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req);
endmodule

// File: rtl/thread_store_queue.sv
module thread_store_queue #(
    parameter int NUM_THR = 4,
    parameter int DEPTH   = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        st_valid,
    input  logic [$clog2(NUM_THR)-1:0]  st_tid,
    input  logic [ADDR_W-1:0]           st_addr,
    input  logic [DATA_W-1:0]           st_data,
    input  logic [DATA_W/8-1:0]         st_mask,
    output logic [NUM_THR-1:0]          st_stall,
    input  logic                        ld_valid,
    input  logic [$clog2(NUM_THR)-1:0]  ld_tid,
    input  logic [ADDR_W-1:0]           ld_addr,
    input  logic [DATA_W/8-1:0]         ld_mask,
    output logic                        ld_hit,
    output logic                        ld_replay,
    output logic [DATA_W-1:0]           ld_data,
    output logic                        drain_valid,
    output logic [$clog2(NUM_THR)-1:0]  drain_tid,
    output logic [ADDR_W-1:0]           drain_addr,
    output logic [DATA_W-1:0]           drain_data,
    output logic [DATA_W/8-1:0]         drain_mask,
    input  logic                        drain_ack
);
    localparam int MASK_W = DATA_W / 8;

    logic [NUM_THR-1:0] full_v, empty_v, hit_v, part_v, push_v, pop_v;
    logic [ADDR_W-1:0]  head_addr_a [NUM_THR];
    logic [DATA_W-1:0]  head_data_a [NUM_THR];
    logic [MASK_W-1:0]  head_mask_a [NUM_THR];
    logic [DATA_W-1:0]  lk_data_a   [NUM_THR];

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        assign push_v[t] = st_valid && (st_tid == t) && !full_v[t];
        sq_thread_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (push_v[t]),
            .push_addr  (st_addr),
            .push_data  (st_data),
            .push_mask  (st_mask),
            .pop        (pop_v[t]),
            .full       (full_v[t]),
            .empty      (empty_v[t]),
            .head_addr  (head_addr_a[t]),
            .head_data  (head_data_a[t]),
            .head_mask  (head_mask_a[t]),
            .lk_addr    (ld_addr),
            .lk_mask    (ld_mask),
            .lk_hit     (hit_v[t]),
            .lk_partial (part_v[t]),
            .lk_data    (lk_data_a[t])
        );
    end

    sq_drain_arb #(.NUM_THR(NUM_THR)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .nonempty  (~empty_v),
        .ack       (drain_ack),
        .req       (drain_valid),
        .grant_tid (drain_tid),
        .pop_vec   (pop_v)
    );

    assign st_stall   = full_v;
    assign drain_addr = head_addr_a[drain_tid];
    assign drain_data = head_data_a[drain_tid];
    assign drain_mask = head_mask_a[drain_tid];
    assign ld_hit     = ld_valid && hit_v[ld_tid];
    assign ld_replay  = ld_valid && part_v[ld_tid];
    assign ld_data    = ld_hit ? lk_data_a[ld_tid] : '0;

    a_r4_hit_replay_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_hit && ld_replay));
endmodule

// File: tb/tb_thread_store_queue.sv
module tb_thread_store_queue;
    localparam int NT = 4, DP = 8, AW = 16, DW = 64, MW = 8;

    logic clk = 0, rst_n = 0;
    logic st_valid = 0; logic [1:0] st_tid = 0; logic [AW-1:0] st_addr = 0;
    logic [DW-1:0] st_data = 0; logic [MW-1:0] st_mask = 0;
    logic [NT-1:0] st_stall;
    logic ld_valid = 0; logic [1:0] ld_tid = 0; logic [AW-1:0] ld_addr = 0;
    logic [MW-1:0] ld_mask = 0;
    logic ld_hit, ld_replay; logic [DW-1:0] ld_data;
    logic drain_valid; logic [1:0] drain_tid; logic [AW-1:0] drain_addr;
    logic [DW-1:0] drain_data; logic [MW-1:0] drain_mask; logic drain_ack = 0;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    thread_store_queue #(.NUM_THR(NT), .DEPTH(DP), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_tid(st_tid), .st_addr(st_addr), .st_data(st_data),
        .st_mask(st_mask), .st_stall(st_stall),
        .ld_valid(ld_valid), .ld_tid(ld_tid), .ld_addr(ld_addr), .ld_mask(ld_mask),
        .ld_hit(ld_hit), .ld_replay(ld_replay), .ld_data(ld_data),
        .drain_valid(drain_valid), .drain_tid(drain_tid), .drain_addr(drain_addr),
        .drain_data(drain_data), .drain_mask(drain_mask), .drain_ack(drain_ack));

    function automatic logic [DW-1:0] pat(input int t, input int i);
        return 64'h1111_0000_0000_0000 * (t + 1) + 64'(i * 3 + 5);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input int t, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [MW-1:0] m);
        @(negedge clk);
        st_valid = 1; st_tid = 2'(t); st_addr = a; st_data = d; st_mask = m;
        @(posedge clk); #1;
        st_valid = 0;
    endtask

    task automatic probe(input string req, input int t, input logic [AW-1:0] a, input logic [MW-1:0] m,
                         input logic eh, input logic er, input logic [DW-1:0] ed);
        @(negedge clk);
        ld_valid = 1; ld_tid = 2'(t); ld_addr = a; ld_mask = m;
        #1;
        check({req, " hit"}, 64'(ld_hit), 64'(eh));
        check({req, " replay"}, 64'(ld_replay), 64'(er));
        if (eh) check({req, " data"}, ld_data, ed);
        ld_valid = 0;
    endtask

    task automatic drain_expect(input string req, input int t, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int guard = 0;
        @(negedge clk); #1;
        while (!drain_valid && guard < 20) begin @(negedge clk); #1; guard++; end
        check({req, " valid"}, 64'(drain_valid), 64'd1);
        check({req, " tid"}, 64'(drain_tid), 64'(t));
        check({req, " addr"}, 64'(drain_addr), 64'(a));
        check({req, " data"}, drain_data, d);
        drain_ack = 1;
        @(posedge clk); #1;
        drain_ack = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        #1;
        check("R1 stall", 64'(st_stall), 64'd0);
        check("R1 drain_valid", 64'(drain_valid), 64'd0);
        probe("R1 empty load", 0, 16'h0040, 8'hFF, 0, 0, 0);

        // R3/R4/R6: youngest match on thread 2, drain held back
        push(2, 16'h0040, 64'hAAAA_BBBB_CCCC_DDDD, 8'hFF);
        push(2, 16'h0040, 64'h0000_0000_1234_5678, 8'h0F);
        probe("R3 youngest full cover", 2, 16'h0040, 8'h0F, 1, 0, 64'h0000_0000_1234_5678);
        probe("R4 partial youngest", 2, 16'h0040, 8'hFF, 0, 1, 0);
        probe("R6 disjoint youngest, older covers", 2, 16'h0040, 8'hF0, 1, 0, 64'hAAAA_BBBB_CCCC_DDDD);
        probe("R5 other thread same addr", 1, 16'h0040, 8'hFF, 0, 0, 0);
        probe("R6 other address", 2, 16'h0041, 8'hFF, 0, 0, 0);
        @(negedge clk); ld_valid = 0; ld_tid = 2; ld_addr = 16'h0040; ld_mask = 8'h0F; #1;
        check("R6 ld_valid low", 64'({ld_hit, ld_replay}), 64'd0);

        // R7: oldest of thread 2 drains first, then is gone
        drain_expect("R7 first drain", 2, 16'h0040, 64'hAAAA_BBBB_CCCC_DDDD);
        check("R9 gap after ack", 64'(drain_valid), 64'd0);
        drain_ack = 1;                       // R9: ack with no request
        @(posedge clk); #1;
        drain_ack = 0;
        check("R9 request after ignored ack", 64'(drain_valid), 64'd1);
        check("R9 younger still queued", drain_data, 64'h0000_0000_1234_5678);
        probe("R7 freed entry no longer forwards", 2, 16'h0040, 8'hF0, 0, 0, 0);
        probe("R9 younger still forwards", 2, 16'h0040, 8'h0F, 1, 0, 64'h0000_0000_1234_5678);
        drain_expect("R7 second drain", 2, 16'h0040, 64'h0000_0000_1234_5678);
        @(negedge clk); #1;
        check("R7 all empty", 64'(drain_valid), 64'd0);

        // R2: fill every queue with the same address set
        for (int t = 0; t < NT; t++) begin
            for (int i = 0; i < DP; i++) begin
                push(t, 16'h0100 + 16'(i), pat(t, i), 8'hFF);
                check($sformatf("R2 stall t%0d n%0d", t, i + 1), 64'(st_stall),
                      64'((1 << (t + 1)) - 1 - ((i == DP - 1) ? 0 : (1 << t))));
            end
        end
        push(0, 16'h01FF, 64'hDEAD, 8'hFF);
        probe("R2 store to full queue dropped", 0, 16'h01FF, 8'hFF, 0, 0, 0);
        check("R2 stall after drop", 64'(st_stall), 64'hF);

        // R3/R5: every entry forwards its own thread's data
        for (int t = 0; t < NT; t++)
            for (int i = 0; i < DP; i++)
                probe($sformatf("R5 R3 t%0d e%0d", t, i), t, 16'h0100 + 16'(i), 8'h3C, 1, 0, pat(t, i));

        // R7/R8: round-robin drain order across full queues
        for (int k = 0; k < NT * DP; k++) begin
            drain_expect($sformatf("R8 R7 drain %0d", k), k % NT, 16'h0100 + 16'(k / NT), pat(k % NT, k / NT));
            if (k == 0) check("R2 stall released", 64'(st_stall), 64'hE);
        end
        @(negedge clk); #1;
        check("R2 all stalls clear", 64'(st_stall), 64'd0);
        check("R7 drain idle", 64'(drain_valid), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule